// File: doc/BRIEF.md
# Iterative Signed/Unsigned Multiply-Divide Unit

This block computes integer products and quotients for three operand sizes (8, 16 and 32 bits) over a shared iterative datapath. A multiply takes one operand-size value from the accumulator-side input and one from the operand input, and returns a product of twice the operand size. The low half goes to the accumulator-side result and the high half to the data-side result. A divide joins the data-side input (upper half) and the accumulator-side input (lower half) into a double-size dividend and divides it by the operand input. The quotient goes to the accumulator-side result and the remainder to the data-side result.

A single-cycle `start` launches an operation and `busy` stays high while it runs. A one-cycle `done` pulse marks its completion. A multiply raises `carry` and `ovf` when the upper half of the product carries information. A divide whose divisor is zero, or whose quotient does not fit the operand size, reports `div_err` and leaves both results untouched. Signed operations use two's complement, with magnitudes formed before the iteration and signs applied after it.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `carry`, `ovf` and `div_err` are 0, and `res_acc` and `res_dat` are all zeros.
- R2: `op` encodes 00 = unsigned multiply, 01 = signed multiply, 10 = unsigned divide and 11 = signed divide. `size` encodes 00 = 8 bits, 01 = 16 bits and 10/11 = 32 bits. Only the low W input bits of the selected size W are used. An unsigned multiply writes product bits [W-1:0] to `res_acc` and bits [2W-1:W] to `res_dat`, and result bits above W are 0.
- R3: A signed multiply treats both operands as W-bit two's complement values and writes the 2W-bit two's complement product split as in R2. With W = 8, FFH times FEH gives `res_dat`:`res_acc` = FDH:02H unsigned and 00H:02H signed.
- R4: On a multiply, `carry` and `ovf` are both set to 1 exactly when the upper half is significant: nonzero for unsigned, not a sign extension of the lower half for signed. Otherwise both are set to 0. A divide leaves both unchanged.
- R5: When `keep_low` is 1 at start, a multiply writes 0 to `res_dat`. `res_acc`, `carry` and `ovf` are as in R2 to R4.
- R6: An unsigned divide of {`src_dat`[W-1:0], `src_acc`[W-1:0]} by `src_opd`[W-1:0] writes the quotient to `res_acc` and the remainder to `res_dat`.
- R7: A signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend (or is zero).
- R8: A divide with a zero divisor, or with a quotient outside the W-bit unsigned range (unsigned divide) or the signed range (signed divide), completes with `div_err` = 1 and leaves `res_acc` and `res_dat` unchanged. Every other completion gives `div_err` = 0.
- R9: Counting from the clock edge that accepts `start`, `done` rises after W+1 edges for a multiply and 2W+1 edges for a divide, and lasts one cycle. `busy` is 1 from the accepting edge until the edge that raises `done`, and 0 while `done` is high.
- R10: `start` while `busy` is 1 is ignored: the running operation's results and timing are unaffected, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, accepted when not busy |
| op | input | 2 | Operation select (R2 encoding) |
| size | input | 2 | Operand size select (R2 encoding) |
| keep_low | input | 1 | Multiply keeps only the low half |
| src_acc | input | XLEN | Multiplicand, or lower dividend half |
| src_dat | input | XLEN | Upper dividend half |
| src_opd | input | XLEN | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_acc | output | XLEN | Product low half or quotient |
| res_dat | output | XLEN | Product high half or remainder |
| carry | output | 1 | Multiply upper half significant |
| ovf | output | 1 | Same condition as carry |
| div_err | output | 1 | Divide error on last completion |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle, because `start` is accepted while `done` is high. The bench drives every operation's `start` in the `done` cycle of the one before it. It then judges the second operation's results, flags and edge count against arithmetic expectations, and checks that results left by an erroring divide survive into the next operation. A second overlap, a `start` in the middle of a run, is provoked with different operands. It is judged by the running result, its latency, and the absence of a further `done`.

// File: rtl/muldiv_pkg.sv
// Shared constants and helpers for the multiply-divide unit.
// Assumes the operand width XLEN is 8, 16 or 32.
package muldiv_pkg;

    localparam logic [1:0] OP_MULU = 2'b00;
    localparam logic [1:0] OP_MULS = 2'b01;
    localparam logic [1:0] OP_DIVU = 2'b10;
    localparam logic [1:0] OP_DIVS = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } md_state_e;

    // Operand width selected by the size code, capped at xlen.
    function automatic int unsigned op_width(input logic [1:0] sz, input int unsigned xlen);
        int unsigned w;
        case (sz)
            2'b00:   w = 8;
            2'b01:   w = 16;
            default: w = 32;
        endcase
        if (w > xlen) w = xlen;
        return w;
    endfunction

    // Number of datapath iterations: one per product bit row, one per dividend bit.
    function automatic int unsigned op_iters(input logic [1:0] opc, input logic [1:0] sz,
                                             input int unsigned xlen);
        int unsigned w;
        w = op_width(sz, xlen);
        return opc[1] ? 2 * w : w;
    endfunction

endpackage

// File: rtl/muldiv_ctrl.sv
// Sequencer: accepts a start when idle, latches the command, counts the
// iterations and then spends one finishing cycle.
// Assumes start is ignored whenever the state is not idle.
module muldiv_ctrl #(
    parameter int XLEN = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op_i,
    input  logic [1:0] size_i,
    input  logic       keep_low_i,
    output logic       load_o,
    output logic       step_o,
    output logic       fin_o,
    output logic       busy_o,
    output logic [1:0] op_q,
    output logic [1:0] size_q,
    output logic       keep_low_q
);
    import muldiv_pkg::*;

    localparam int CW = $clog2(2 * XLEN + 1);

    md_state_e   state;
    logic [CW-1:0] cnt;
    int unsigned iters;

    // Iteration count of the command being offered.
    always_comb begin : iter_calc
        iters = op_iters(op_i, size_i, XLEN);
    end

    // State, iteration counter and command latch.
    always_ff @(posedge clk) begin : ctrl_seq
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            op_q       <= '0;
            size_q     <= '0;
            keep_low_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_RUN;
                        cnt        <= CW'(iters - 1);
                        op_q       <= op_i;
                        size_q     <= size_i;
                        keep_low_q <= keep_low_i;
                    end
                end
                ST_RUN: begin
                    if (cnt == '0) state <= ST_FIN;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobes decoded from the state.
    always_comb begin : strobes
        load_o = (state == ST_IDLE) && start;
        step_o = (state == ST_RUN);
        fin_o  = (state == ST_FIN);
        busy_o = (state != ST_IDLE);
    end

endmodule

// File: rtl/muldiv_core.sv
// Iterative datapath. On load it turns the operands into magnitudes and
// records the result signs. Each step then does one shift-add row of a
// multiply (MSB first) or one restoring-divide bit.
// Assumes load and step are never high together.
module muldiv_core #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [1:0]        op_q,
    input  logic [1:0]        size_q,
    input  logic [XLEN-1:0]   src_acc,
    input  logic [XLEN-1:0]   src_dat,
    input  logic [XLEN-1:0]   src_opd,
    output logic [2*XLEN-1:0] acc_o,
    output logic [XLEN-1:0]   rem_o,
    output logic [XLEN-1:0]   dvs_o,
    output logic              neg_res_o,
    output logic              neg_rem_o
);
    import muldiv_pkg::*;

    localparam int DW = 2 * XLEN;

    logic [XLEN-1:0] mag_q;
    logic [DW-1:0]   sh_q;
    logic [DW-1:0]   acc_q;
    logic [XLEN-1:0] rem_q;
    logic            neg_res_q;
    logic            neg_rem_q;

    int unsigned     w_in;
    int unsigned     w_run;
    logic [XLEN-1:0] mask, top;
    logic [DW-1:0]   mask2;
    logic [XLEN-1:0] a_raw, b_raw, h_raw;
    logic            a_neg, b_neg, d_neg, sgn;
    logic [XLEN-1:0] a_mag, b_mag;
    logic [DW-1:0]   dvd, dvd_mag;

    logic [DW-1:0]   pick;
    logic            nxt_bit;
    logic [XLEN:0]   trial;
    logic            fits;

    // Operand magnitudes and signs for the command being loaded.
    always_comb begin : load_prep
        w_in    = op_width(size_i, XLEN);
        mask    = {XLEN{1'b1}} >> (XLEN - w_in);
        mask2   = {DW{1'b1}} >> (DW - 2 * w_in);
        top     = XLEN'(1) << (w_in - 1);
        sgn     = op_i[0];
        a_raw   = src_acc & mask;
        b_raw   = src_opd & mask;
        h_raw   = src_dat & mask;
        a_neg   = sgn && (|(a_raw & top));
        b_neg   = sgn && (|(b_raw & top));
        d_neg   = sgn && (|(h_raw & top));
        a_mag   = a_neg ? ((~a_raw + XLEN'(1)) & mask) : a_raw;
        b_mag   = b_neg ? ((~b_raw + XLEN'(1)) & mask) : b_raw;
        dvd     = (DW'(h_raw) << w_in) | DW'(a_raw);
        dvd_mag = d_neg ? ((~dvd + DW'(1)) & mask2) : dvd;
    end

    // Next source bit, taken at the top of the active field, and the divide trial.
    always_comb begin : step_prep
        w_run   = op_width(size_q, XLEN);
        pick    = op_q[1] ? (DW'(1) << (2 * w_run - 1)) : (DW'(1) << (w_run - 1));
        nxt_bit = |(sh_q & pick);
        trial   = {rem_q, nxt_bit};
        fits    = (trial >= {1'b0, mag_q});
    end

    // Datapath registers: loaded at start, advanced once per iteration.
    always_ff @(posedge clk) begin : core_seq
        if (!rst_n) begin
            mag_q     <= '0;
            sh_q      <= '0;
            acc_q     <= '0;
            rem_q     <= '0;
            neg_res_q <= 1'b0;
            neg_rem_q <= 1'b0;
        end else if (load_i) begin
            acc_q <= '0;
            rem_q <= '0;
            if (op_i[1]) begin
                mag_q     <= b_mag;
                sh_q      <= dvd_mag;
                neg_res_q <= d_neg ^ b_neg;
                neg_rem_q <= d_neg;
            end else begin
                mag_q     <= a_mag;
                sh_q      <= DW'(b_mag);
                neg_res_q <= a_neg ^ b_neg;
                neg_rem_q <= 1'b0;
            end
        end else if (step_i) begin
            sh_q <= sh_q << 1;
            if (op_q[1]) begin
                if (fits) begin
                    rem_q <= XLEN'(trial - {1'b0, mag_q});
                    acc_q <= {acc_q[DW-2:0], 1'b1};
                end else begin
                    rem_q <= XLEN'(trial);
                    acc_q <= {acc_q[DW-2:0], 1'b0};
                end
            end else begin
                acc_q <= (acc_q << 1) + DW'(nxt_bit ? mag_q : '0);
            end
        end
    end

    assign acc_o     = acc_q;
    assign rem_o     = rem_q;
    assign dvs_o     = mag_q;
    assign neg_res_o = neg_res_q;
    assign neg_rem_o = neg_rem_q;

endmodule

// File: rtl/muldiv_fix.sv
// Result formation: applies the signs to the magnitudes, splits a product
// into halves, and judges product significance and divide validity.
// Purely combinational; valid during the finishing cycle.
module muldiv_fix #(
    parameter int XLEN = 32
) (
    input  logic [1:0]        op_q,
    input  logic [1:0]        size_q,
    input  logic              keep_low_q,
    input  logic [2*XLEN-1:0] acc_i,
    input  logic [XLEN-1:0]   rem_i,
    input  logic [XLEN-1:0]   dvs_i,
    input  logic              neg_res_i,
    input  logic              neg_rem_i,
    output logic [XLEN-1:0]   res_lo_o,
    output logic [XLEN-1:0]   res_hi_o,
    output logic              sig_o,
    output logic              err_o
);
    import muldiv_pkg::*;

    localparam int DW = 2 * XLEN;

    int unsigned     w;
    logic [XLEN-1:0] mask, top, ext;
    logic [DW-1:0]   mask2, prod, lim;
    logic [XLEN-1:0] p_lo, p_hi, q_lo, q_val, r_lo, r_val;
    logic            mul_sig, q_ovf, dz;

    // Sign application, splitting and error judgement.
    always_comb begin : fix_comb
        w     = op_width(size_q, XLEN);
        mask  = {XLEN{1'b1}} >> (XLEN - w);
        mask2 = {DW{1'b1}} >> (DW - 2 * w);
        top   = XLEN'(1) << (w - 1);

        prod    = (neg_res_i ? (~acc_i + DW'(1)) : acc_i) & mask2;
        p_lo    = XLEN'(prod) & mask;
        p_hi    = XLEN'(prod >> w) & mask;
        ext     = (|(p_lo & top)) ? mask : '0;
        mul_sig = op_q[0] ? (p_hi != ext) : (p_hi != '0);

        if (op_q[0]) lim = neg_res_i ? DW'(top) : (DW'(top) - DW'(1));
        else         lim = DW'(mask);
        dz    = (dvs_i == '0);
        q_ovf = (acc_i > lim);
        q_lo  = XLEN'(acc_i) & mask;
        q_val = neg_res_i ? ((~q_lo + XLEN'(1)) & mask) : q_lo;
        r_lo  = rem_i & mask;
        r_val = neg_rem_i ? ((~r_lo + XLEN'(1)) & mask) : r_lo;

        if (op_q[1]) begin
            res_lo_o = q_val;
            res_hi_o = r_val;
            sig_o    = 1'b0;
            err_o    = dz | q_ovf;
        end else begin
            res_lo_o = p_lo;
            res_hi_o = keep_low_q ? '0 : p_hi;
            sig_o    = mul_sig;
            err_o    = 1'b0;
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
// Top of the multiply-divide unit: sequencer, datapath, result formation
// and the registered result and flag outputs.
// Assumes XLEN is 8, 16 or 32; size codes wider than XLEN clamp to XLEN.
module muldiv_unit #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [1:0]      size,
    input  logic            keep_low,
    input  logic [XLEN-1:0] src_acc,
    input  logic [XLEN-1:0] src_dat,
    input  logic [XLEN-1:0] src_opd,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] res_acc,
    output logic [XLEN-1:0] res_dat,
    output logic            carry,
    output logic            ovf,
    output logic            div_err
);

    logic              load_s, step_s, fin_s;
    logic [1:0]        op_q, size_q;
    logic              keep_low_q;
    logic [2*XLEN-1:0] acc_s;
    logic [XLEN-1:0]   rem_s, dvs_s, lo_s, hi_s;
    logic              neg_res_s, neg_rem_s, sig_s, err_s;

    muldiv_ctrl #(.XLEN(XLEN)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_i       (op),
        .size_i     (size),
        .keep_low_i (keep_low),
        .load_o     (load_s),
        .step_o     (step_s),
        .fin_o      (fin_s),
        .busy_o     (busy),
        .op_q       (op_q),
        .size_q     (size_q),
        .keep_low_q (keep_low_q)
    );

    muldiv_core #(.XLEN(XLEN)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_s),
        .step_i    (step_s),
        .op_i      (op),
        .size_i    (size),
        .op_q      (op_q),
        .size_q    (size_q),
        .src_acc   (src_acc),
        .src_dat   (src_dat),
        .src_opd   (src_opd),
        .acc_o     (acc_s),
        .rem_o     (rem_s),
        .dvs_o     (dvs_s),
        .neg_res_o (neg_res_s),
        .neg_rem_o (neg_rem_s)
    );

    muldiv_fix #(.XLEN(XLEN)) fix_i (
        .op_q       (op_q),
        .size_q     (size_q),
        .keep_low_q (keep_low_q),
        .acc_i      (acc_s),
        .rem_i      (rem_s),
        .dvs_i      (dvs_s),
        .neg_res_i  (neg_res_s),
        .neg_rem_i  (neg_rem_s),
        .res_lo_o   (lo_s),
        .res_hi_o   (hi_s),
        .sig_o      (sig_s),
        .err_o      (err_s)
    );

    // Output registers: written once in the finishing cycle.
    always_ff @(posedge clk) begin : out_seq
        if (!rst_n) begin
            done    <= 1'b0;
            res_acc <= '0;
            res_dat <= '0;
            carry   <= 1'b0;
            ovf     <= 1'b0;
            div_err <= 1'b0;
        end else begin
            done <= fin_s;
            if (fin_s) begin
                div_err <= err_s;
                if (!err_s) begin
                    res_acc <= lo_s;
                    res_dat <= hi_s;
                end
                if (!op_q[1]) begin
                    carry <= sig_s;
                    ovf   <= sig_s;
                end
            end
        end
    end

endmodule

// File: rtl/muldiv_unit_chk.sv
// Property checker for the multiply-divide unit, attached by bind.
// It tracks the command accepted at each start and the edges since then,
// and relates them to the completion outputs.
module muldiv_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [1:0]      op,
    input logic [1:0]      size,
    input logic            keep_low,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] res_acc,
    input logic [XLEN-1:0] res_dat,
    input logic            carry,
    input logic            ovf,
    input logic            div_err
);
    import muldiv_pkg::*;

    localparam int KW = $clog2(2 * XLEN + 3) + 1;

    logic [1:0]    c_op, c_sz;
    logic          c_keep;
    logic [KW-1:0] c_cnt;
    int unsigned   c_exp;
    logic [XLEN-1:0] c_mask;

    // Command and edge count since the last accepted start.
    always_ff @(posedge clk) begin : track
        if (!rst_n) begin
            c_op   <= '0;
            c_sz   <= '0;
            c_keep <= 1'b0;
            c_cnt  <= '0;
        end else if (start && !busy) begin
            c_op   <= op;
            c_sz   <= size;
            c_keep <= keep_low;
            c_cnt  <= '0;
        end else if (c_cnt != '1) begin
            c_cnt <= c_cnt + 1'b1;
        end
    end

    // Expected completion edge count and result mask of the tracked command.
    always_comb begin : expect_calc
        c_exp  = op_iters(c_op, c_sz, XLEN) + 1;
        c_mask = {XLEN{1'b1}} >> (XLEN - op_width(c_sz, XLEN));
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(c_cnt) == c_exp)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R9
    AST_BUSY_CLEAR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_ERR_KEEPS_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_err) |-> ($stable(res_acc) && $stable(res_dat))); // R8
    AST_ERR_ONLY_DIVIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !c_op[1]) |-> !div_err); // R8
    AST_DIVIDE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_op[1]) |-> ($stable(carry) && $stable(ovf))); // R4
    AST_UNSIGNED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_op == OP_MULU && !c_keep) |-> (carry == (res_dat != '0))); // R4
    AST_KEEP_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !c_op[1] && c_keep) |-> (res_dat == '0)); // R5
    AST_RESULT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_err) |-> (((res_acc | res_dat) & ~c_mask) == '0)); // R2

endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .size     (size),
    .keep_low (keep_low),
    .busy     (busy),
    .done     (done),
    .res_acc  (res_acc),
    .res_dat  (res_dat),
    .carry    (carry),
    .ovf      (ovf),
    .div_err  (div_err)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: near-exhaustive 8-bit sweeps, pseudo-random
// 16/32-bit patterns and directed corners, with an arithmetic model.
module muldiv_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [1:0]  size = '0;
    logic        keep_low = 1'b0;
    logic [31:0] src_acc = '0, src_dat = '0, src_opd = '0;
    logic        busy, done, carry, ovf, div_err;
    logic [31:0] res_acc, res_dat;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_acc = '0, m_dat = '0;
    logic        m_c = 1'b0, m_o = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    muldiv_unit #(.XLEN(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .keep_low(keep_low), .src_acc(src_acc), .src_dat(src_dat), .src_opd(src_opd),
        .busy(busy), .done(done), .res_acc(res_acc), .res_dat(res_dat),
        .carry(carry), .ovf(ovf), .div_err(div_err)
    );

    function automatic logic [31:0] rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic longint sx(input logic [63:0] v, input int bits);
        if (bits >= 64) return longint'(v);
        if (((v >> (bits - 1)) & 64'h1) != 0) return longint'(v | ~((64'h1 << bits) - 1));
        return longint'(v);
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one command starting at a negedge; returns at the negedge where done is seen.
    task automatic run_op(input logic [1:0] o, input logic [1:0] sz, input logic kl,
                          input logic [31:0] a, input logic [31:0] h, input logic [31:0] b,
                          input logic poke);
        int w, lat;
        logic [63:0] mask, am, hm, bm, n, lo, hi, uq, ur;
        longint sp, sn, sd, sq, sr, lo_b, hi_b;
        logic [31:0] e_acc, e_dat;
        logic e_c, e_o, e_err, sig;
        string tag;

        w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        mask = (64'h1 << w) - 1;
        am = a & mask; hm = h & mask; bm = b & mask;
        e_acc = m_acc; e_dat = m_dat; e_c = m_c; e_o = m_o; e_err = 1'b0;
        if (!o[1]) begin
            if (o[0]) begin
                sp  = sx(am, w) * sx(bm, w);
                lo  = 64'(sp) & mask;
                hi  = (64'(sp) >> w) & mask;
                sig = (sp != sx(lo, w));
                tag = kl ? "R5" : "R3/R4";
            end else begin
                n   = am * bm;
                lo  = n & mask;
                hi  = (n >> w) & mask;
                sig = (hi != 0);
                tag = kl ? "R5" : "R2/R4";
            end
            e_acc = 32'(lo); e_dat = kl ? 32'h0 : 32'(hi); e_c = sig; e_o = sig;
        end else begin
            n = (hm << w) | am;
            if (bm == 0) begin
                e_err = 1'b1;
            end else if (!o[1] || !o[0]) begin
                uq = n / bm; ur = n % bm;
                if (uq > mask) e_err = 1'b1;
                else begin e_acc = 32'(uq); e_dat = 32'(ur); end
            end else begin
                sn = sx(n, 2 * w); sd = sx(bm, w);
                lo_b = -(longint'(1) << (w - 1));
                hi_b = (longint'(1) << (w - 1)) - 1;
                if (sd == -1 && sn == lo_b * (longint'(1) << w) && w == 32) e_err = 1'b1;
                else begin
                    sq = sn / sd; sr = sn % sd;
                    if (sq < lo_b || sq > hi_b) e_err = 1'b1;
                    else begin e_acc = 32'(64'(sq) & mask); e_dat = 32'(64'(sr) & mask); end
                end
            end
            tag = o[0] ? "R7/R8" : "R6/R8";
        end

        op = o; size = sz; keep_low = kl; src_acc = a; src_dat = h; src_opd = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "busy after accept", 64'(busy), 64'h1);
        lat = 0;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 1) begin
                start = 1'b1; op = ~o; size = ~sz; src_acc = rnd(); src_dat = rnd(); src_opd = rnd();
            end else if (poke && lat == 2) begin
                start = 1'b0;
            end
        end
        check(poke ? "R10" : "R9", "edges to done", 64'(lat), 64'((o[1] ? 2 * w : w) + 1));
        check(poke ? "R10" : tag, "results acc:dat", {res_acc, res_dat}, {e_acc, e_dat});
        check(poke ? "R10" : tag, "carry,ovf,div_err", {61'h0, carry, ovf, div_err},
              {61'h0, e_c, e_o, e_err});
        m_acc = e_acc; m_dat = e_dat; m_c = e_c; m_o = e_o;
    endtask

    function automatic logic [31:0] v8(input int i);
        return 32'((i * 8) | (i % 8));
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog: actual=no completion expected=completion within 190000 cycles");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy,done,flags", {59'h0, busy, done, carry, ovf, div_err}, 64'h0);
        check("R1", "results", {res_acc, res_dat}, 64'h0);

        // Directed corners (R3): FFH x FEH
        run_op(2'b00, 2'b00, 1'b0, 32'hFF, 32'h0, 32'hFE, 1'b0);
        check("R3", "unsigned FF*FE", {32'h0, res_dat[15:0], res_acc[15:0]}, 64'h00FD_0002);
        run_op(2'b01, 2'b00, 1'b0, 32'hAAAA_FFFF, 32'h0, 32'h5555_FFFE, 1'b0);
        check("R3", "signed FF*FE", {32'h0, res_dat[15:0], res_acc[15:0]}, 64'h0000_0002);
        // R8: zero divisor after a good result, then quotient overflow, signed limit cases
        run_op(2'b10, 2'b00, 1'b0, 32'h34, 32'h12, 32'h0, 1'b0);
        run_op(2'b10, 2'b00, 1'b0, 32'h00, 32'h01, 32'h1, 1'b0);
        run_op(2'b11, 2'b00, 1'b0, 32'h80, 32'hFF, 32'h1, 1'b0);
        check("R7", "signed -128/1 quotient", 64'(res_acc), 64'h80);
        run_op(2'b11, 2'b00, 1'b0, 32'h80, 32'hFF, 32'hFF, 1'b0);
        check("R8", "signed -128/-1 keeps quotient", 64'(res_acc), 64'h80);
        run_op(2'b11, 2'b00, 1'b0, 32'hF9, 32'hFF, 32'h2, 1'b0);
        check("R7", "signed -7/2 rem", {res_dat[7:0], res_acc[7:0]}, 64'hFFFD);
        // R10: start during a run is ignored
        run_op(2'b01, 2'b01, 1'b0, 32'h8000, 32'h0, 32'h7FFF, 1'b1);
        repeat (4) begin
            @(negedge clk);
            check("R10", "no extra done", {62'h0, done, busy}, 64'h0);
        end

        // Near-exhaustive 8-bit sweeps
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++) begin
                run_op(2'b00, 2'b00, 1'b0, v8(i) | 32'hABCD_0000, 32'h0, v8(j), 1'b0);
                run_op(2'b01, 2'b00, 1'b0, v8(i), 32'h0, v8(j) | 32'h1100, 1'b0);
            end
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++) begin
                run_op(2'b10, 2'b00, 1'b0, 32'((i * 37) & 255), v8(i) >> (j % 8), v8(j), 1'b0);
                run_op(2'b11, 2'b00, 1'b0, 32'((j * 53) & 255), v8(i) >> (j % 8), v8(j), 1'b0);
            end
        // Keep-low multiplies (R5) and wider sizes
        for (int k = 0; k < 40; k++) begin
            run_op(2'b00, 2'(k % 3), 1'b1, rnd(), rnd(), rnd(), 1'b0);
            run_op(2'b01, 2'(k % 3), 1'b1, rnd(), rnd(), rnd(), 1'b0);
        end
        for (int k = 0; k < 120; k++) begin
            run_op(2'b00, 2'b01, 1'b0, rnd(), rnd(), rnd(), 1'b0);
            run_op(2'b01, 2'b01, 1'b0, rnd(), rnd(), rnd(), 1'b0);
            run_op(2'b10, 2'b01, 1'b0, rnd(), rnd() >> (k % 17), rnd(), 1'b0);
            run_op(2'b11, 2'b01, 1'b0, rnd(), rnd() >> (k % 17), rnd(), 1'b0);
        end
        for (int k = 0; k < 90; k++) begin
            run_op(2'b00, 2'b10, 1'b0, rnd(), rnd(), rnd() >> (k % 33), 1'b0);
            run_op(2'b01, 2'b11, 1'b0, rnd(), rnd(), rnd() >> (k % 33), 1'b0);
            run_op(2'b10, 2'b10, 1'b0, rnd(), rnd() >> (k % 33), rnd(), 1'b0);
            run_op(2'b11, 2'b10, 1'b0, rnd(), rnd() >> (k % 33), rnd(), 1'b0);
        end
        run_op(2'b11, 2'b10, 1'b0, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op(2'b10, 2'b10, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0);

        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule